// File: doc/BRIEF.md
# Partitioned Physical Register Allocator

This block supplies physical register numbers to a register renamer. It replaces a single free pool with several equal banks of a 64-entry physical register file, and each bank keeps its own set of free registers. Allocation is steered so that renaming activity stays inside as few banks as possible. The banks that hand out no registers can then be power gated and allowed to cool.

At any moment a contiguous run of banks, taken in round-robin order, is open for allocation. The first bank of the run is the home bank. The run begins with the home bank alone and grows by one bank at a time, only when every open bank has run dry. A fixed period counter moves the home bank forward to the bank after the last one opened, and closes all the others. This spreads heat across the whole file over time.

Requests arrive from the rename stage, at most one per cycle. The grant is combinational from the request. Releases arrive from commit and always return a register to the bank that owns its index.

Top module: `part_reg_alloc`

## Requirements
- R1: The file of NREG (64) registers is split into NPART equal banks (2, 4 or 8). Bank b owns indices b*NREG/NPART up to (b+1)*NREG/NPART-1, so the upper bits of an index name its bank.
- R2: After reset every register is free and bank 0 is the home bank. `part_active` has only bit 0 set, and with no request `alloc_gnt` and `alloc_stall` are both 0.
- R3: In a cycle with `alloc_req` high and a free register in an open bank, `alloc_gnt` is 1 in that same cycle. `alloc_idx` is then the lowest free index of the first such bank. At most one register is granted per cycle.
- R4: When a request finds no free register in any open bank, the next bank in round-robin order after the last opened one is opened. It supplies the grant in that same cycle, and its bit in `part_active` is set from the next cycle.
- R5: When several open banks have free registers, the grant comes from the bank opened earliest in the current period.
- R6: After every PERIOD rising edges counted from reset, the home bank becomes the bank following the last opened one. All previously open banks close, so `part_active` is one-hot on the new home bank.
- R7: A closed bank gives out no registers even when it holds free ones. A released register returns to the free set of its owning bank even when that bank is closed, and it is handed out once that bank is opened again.
- R8: When a request finds no free register in any bank that is open or could still be opened, `alloc_stall` is 1 and `alloc_gnt` is 0 in that cycle.
- R9: A release and a request in the same cycle both take effect. The released register is not visible to that request, and it can be granted from the next cycle on.
- R10: A granted register is not granted again until it has been released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Rename stage asks for one register |
| rel_valid | input | 1 | Commit returns a register |
| rel_idx | input | $clog2(NREG) | Index of the returned register |
| alloc_gnt | output | 1 | A register is granted this cycle |
| alloc_idx | output | $clog2(NREG) | Granted register index |
| alloc_stall | output | 1 | Request cannot be served this cycle |
| part_active | output | NPART | Bit b set when bank b is open for allocation |

## Verification
`alloc_gnt`, `alloc_idx` and `alloc_stall` respond combinationally in the same cycle as the request. A release, and any bank opened by a grant, show up only after the next rising edge. The home bank moves at the rising edge numbered PERIOD after reset. The bench therefore drives inputs just after a falling edge and samples one time unit later, before the rising edge that commits them. It restarts from reset in every scenario, so each rotation edge falls at a step count known in advance.

// File: rtl/part_reg_alloc.sv
module part_reg_alloc #(
  parameter int NREG   = 64,
  parameter int NPART  = 4,
  parameter int PERIOD = 10000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    alloc_req,
  input  logic                    rel_valid,
  input  logic [$clog2(NREG)-1:0] rel_idx,
  output logic                    alloc_gnt,
  output logic [$clog2(NREG)-1:0] alloc_idx,
  output logic                    alloc_stall,
  output logic [NPART-1:0]        part_active
);
  localparam int PSZ = NREG / NPART;
  localparam int IW  = $clog2(NREG);
  localparam int PW  = $clog2(NPART);
  localparam int OW  = $clog2(PSZ);
  localparam int CW  = $clog2(PERIOD);

  logic [NREG-1:0] free_q, free_n;
  logic [PW-1:0]   dflt_q;
  logic [PW:0]     nact_q, nact_a;
  logic [CW-1:0]   cnt_q;
  logic [NPART-1:0] pfree;
  logic [OW-1:0]   plow [NPART];
  logic            found, tick;
  logic [PW:0]     sel_k;
  logic [PW-1:0]   sel_p;

  for (genvar p = 0; p < NPART; p++) begin : g_part
    logic [PW-1:0] pos;
    assign pfree[p]       = |free_q[p*PSZ +: PSZ];
    assign pos            = PW'(p) - dflt_q;
    assign part_active[p] = {1'b0, pos} < nact_q;
  end

  always_comb begin
    for (int p = 0; p < NPART; p++) begin
      plow[p] = '0;
      for (int i = PSZ - 1; i >= 0; i--)
        if (free_q[p*PSZ + i]) plow[p] = OW'(i);
    end
  end

  always_comb begin
    found = 1'b0;
    sel_k = '0;
    sel_p = dflt_q;
    for (int k = NPART - 1; k >= 0; k--) begin
      if (pfree[PW'(dflt_q + PW'(k))]) begin
        found = 1'b1;
        sel_k = (PW+1)'(k);
        sel_p = PW'(dflt_q + PW'(k));
      end
    end
  end

  assign alloc_gnt   = alloc_req & found;
  assign alloc_stall = alloc_req & ~found;
  assign alloc_idx   = {sel_p, plow[sel_p]};
  assign tick        = (cnt_q == CW'(PERIOD - 1));
  assign nact_a      = (alloc_gnt && sel_k >= nact_q) ? (PW+1)'(sel_k + 1'b1) : nact_q;

  always_comb begin
    free_n = free_q;
    if (alloc_gnt) free_n[alloc_idx] = 1'b0;
    if (rel_valid) free_n[rel_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_q <= '1;
      dflt_q <= '0;
      nact_q <= (PW+1)'(1);
      cnt_q  <= '0;
    end else begin
      free_q <= free_n;
      cnt_q  <= tick ? '0 : cnt_q + 1'b1;
      if (tick) begin
        dflt_q <= dflt_q + PW'(nact_a);
        nact_q <= (PW+1)'(1);
      end else begin
        nact_q <= nact_a;
      end
    end
  end

  assert_granted_taken_R10: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_gnt && !(rel_valid && rel_idx == alloc_idx) |=> !free_q[$past(alloc_idx)]);

  assert_release_owner_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |=> free_q[$past(rel_idx)]);

  assert_stall_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_stall |-> (free_q == '0 && !alloc_gnt));

  assert_grant_bank_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_gnt && !tick |=> part_active[$past(alloc_idx[IW-1 -: PW])]);

  assert_rotate_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tick) |-> $countones(part_active) == 1);

  assert_some_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
    part_active != '0);
endmodule

// File: tb/sim_part_reg_alloc.sv
module sim_part_reg_alloc;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 64;
  localparam int NPART = 4;
  localparam int PERIOD = 100;

  logic clk = 0, rst_n = 0, alloc_req = 0, rel_valid = 0;
  logic [5:0] rel_idx = '0;
  logic alloc_gnt, alloc_stall;
  logic [5:0] alloc_idx;
  logic [NPART-1:0] part_active;

  int checks = 0, errors = 0;
  bit done = 0;
  logic s_gnt, s_stall;
  int s_idx, s_act;

  part_reg_alloc #(.NREG(NREG), .NPART(NPART), .PERIOD(PERIOD)) u0 (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .rel_valid(rel_valid),
    .rel_idx(rel_idx), .alloc_gnt(alloc_gnt), .alloc_idx(alloc_idx),
    .alloc_stall(alloc_stall), .part_active(part_active));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; alloc_req = 0; rel_valid = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic step(input bit req, input bit rel, input int ridx);
    alloc_req = req; rel_valid = rel; rel_idx = 6'(ridx);
    #1;
    s_gnt = alloc_gnt; s_stall = alloc_stall;
    s_idx = int'(alloc_idx); s_act = int'(part_active);
    @(negedge clk);
    alloc_req = 0; rel_valid = 0;
  endtask

  task automatic alloc_expect(input int exp, input string rq);
    step(1, 0, 0);
    chk(s_gnt === 1'b1, rq, s_gnt, 1);
    chk(s_idx == exp, rq, s_idx, exp);
  endtask

  task automatic t_reset();
    do_reset();
    step(0, 0, 0);
    chk(s_act == 1, "R2", s_act, 1);
    chk(!s_gnt && !s_stall, "R2", {s_gnt, s_stall}, 0);
    alloc_expect(0, "R3");
    step(0, 0, 0);
    chk(s_act == 1, "R3", s_act, 1);
  endtask

  task automatic t_spill();
    do_reset();
    for (int i = 0; i < 16; i++) alloc_expect(i, "R3");
    alloc_expect(16, "R4");
    step(0, 0, 0);
    chk(s_act == 3, "R4", s_act, 3);
    step(1, 1, 5);
    chk(s_idx == 17, "R9", s_idx, 17);
    alloc_expect(5, "R5");
    alloc_expect(18, "R5");
    chk(18 / (NREG / NPART) == 1, "R1", 18 / (NREG / NPART), 1);
  endtask

  task automatic t_rotate();
    do_reset();
    for (int i = 0; i < 20; i++) step(1, 0, 0);
    for (int i = 20; i < PERIOD; i++) step(0, 0, 0);
    step(0, 1, 3);
    chk(s_act == 4, "R6", s_act, 4);
    alloc_expect(32, "R7");
    for (int i = 33; i < 48; i++) alloc_expect(i, "R6");
    alloc_expect(48, "R4");
    step(0, 0, 0);
    chk(s_act == 12, "R4", s_act, 12);
    for (int i = 49; i < 64; i++) alloc_expect(i, "R4");
    alloc_expect(3, "R7");
    alloc_expect(20, "R4");
    step(0, 0, 0);
    chk(s_act == 15, "R4", s_act, 15);
  endtask

  task automatic t_stall();
    do_reset();
    for (int i = 0; i < NREG; i++) alloc_expect(i, "R10");
    step(1, 0, 0);
    chk(s_stall === 1'b1 && s_gnt === 1'b0, "R8", {s_stall, s_gnt}, 2);
    step(1, 1, 50);
    chk(s_stall === 1'b1 && s_gnt === 1'b0, "R9", {s_stall, s_gnt}, 2);
    alloc_expect(50, "R9");
    step(1, 0, 0);
    chk(s_stall === 1'b1 && s_gnt === 1'b0, "R8", {s_stall, s_gnt}, 2);
  endtask

  initial begin
    t_reset();
    t_spill();
    t_rotate();
    t_stall();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule